// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block gathers a set of interrupt inputs and presents one active-low request line to a processor. Each input has its own priority (0 lowest, 7 highest), a choice between rising-edge and level triggering, and a 32-bit handler address. Software reads a vector register to claim the most urgent enabled pending input and gets back that input's handler address. The read has side effects: the claimed priority becomes the level in service, a pending edge request is cleared, and the request line is released.

The levels in service are kept on a small hardware stack, one entry per priority level. While a handler runs, only a pending request of strictly higher priority than the level in service raises the request line again, so handlers can nest. Writing the end-of-interrupt register pops the stack. After the pop, the line is raised again if any pending request is above the restored level, including one that was not above the level just finished.

All access is through a simple register bus with read and write strobes, a word address and 32-bit data. Reset is synchronous and active-high.

Top module: `vic_nest_top`

## Requirements
- R1: During and after reset, irq_n is 1, the level stack is empty, rdata is 0 and the enable mask reads 0.
- R2: With an empty stack, any enabled pending source drives irq_n to 0. A pending source whose enable bit is 0 does not.
- R3: A read of address 0x40 (vector) returns the handler address of the enabled pending source with the highest priority, choosing the lowest index on equal priority. It returns 0 and pushes nothing when no source is enabled and pending. Read data is valid on the cycle after the read strobe.
- R4: On the clock edge that takes a vector read, irq_n goes to 1, whether or not software uses the returned address.
- R5: An edge-mode source (config bit 4 = 1) sets a sticky pending flag on a rising edge of its input. The flag stays set after the input falls and is cleared only when a vector read selects that source.
- R6: A level-mode source (config bit 4 = 0) is pending exactly while its input is high. A vector read does not clear it.
- R7: While the stack is not empty, irq_n is 0 only if an enabled pending source has a priority strictly above the level on top of the stack.
- R8: A write to address 0x43 (end of interrupt) pops the stack. irq_n is then 0 if a pending source is above the restored level, or if the stack is now empty and any enabled source is pending.
- R9: An end-of-interrupt write to an empty stack changes nothing, so the stack stays empty.
- R10: Address 0x00+i is the config word of source i: bits 2:0 hold the priority and bit 4 holds the mode. Address 0x20+i holds the handler address of source i. Both read back what was written.
- R11: Writing address 0x41 sets, and writing address 0x42 clears, the enable bits given as 1 in wdata. The other bits are left unchanged. A read of address 0x41 returns the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt source inputs |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
A source input takes two synchronizer stages before its pending state is known, one more edge to set an edge flag, and then one edge for the registered irq_n. The bench therefore waits five cycles after changing an input before it samples irq_n. Vector and config read data are sampled one cycle after the strobe, on the falling edge. irq_n is checked on that same falling edge after a vector read. After an end-of-interrupt write, the bench waits one extra edge because the pop and the recomputed request land on consecutive edges. The expected vectors come from a bench function that scans a recorded priority table in ascending index order.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_VEC_READ = 8'h40;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h41;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h42;
  localparam logic [ADDR_W-1:0] A_EOI      = 8'h43;
  localparam int MODE_BIT = 4;
endpackage

// File: rtl/vic_src_sync.sv
module vic_src_sync #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] edge_mode,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic s1, s2, prev, flag;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0; flag <= 1'b0;
      end else begin
        s1   <= src_i[g];
        s2   <= s1;
        prev <= s2;
        if (!edge_mode[g])        flag <= 1'b0;
        else if (s2 && !prev)     flag <= 1'b1;
        else if (clr[g])          flag <= 1'b0;
      end
    end
    assign pend[g] = edge_mode[g] ? flag : s2;
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             req,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           found,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i] && (!found || prio[i] >= win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack #(
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] top_lvl,
  output logic [CNT_W-1:0] depth
);
  logic [LVL_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] below;

  assign empty = (depth == '0);
  assign full  = (depth == CNT_W'(DEPTH));
  assign below = depth - 1'b1;
  assign top_lvl = empty ? '0 : mem[below[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[depth[PTR_W-1:0]] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)                  depth <= '0;
    else if (push && !full)   depth <= depth + 1'b1;
    else if (pop && !empty)   depth <= below;
  end
endmodule

// File: rtl/vic_nest_top.sv
module vic_nest_top #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int ADDR_W = vic_pkg::ADDR_W,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int DEPTH  = 2 ** PRIO_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_n
);
  import vic_pkg::*;
  localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] VEC_END  = ADDR_W'(2 * NUM_SRC);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             edge_q, en_q, pend, clr;
  logic [DATA_W-1:0]              vec_mem [NUM_SRC];
  logic                           found, stk_empty, stk_full, req_hit;
  logic [IDX_W-1:0]               win_idx, reg_idx;
  logic [PRIO_W-1:0]              win_lvl, top_lvl;
  logic [CNT_W-1:0]               stk_depth;
  logic                           in_cfg, in_vec, vec_rd, eoi_wr, push;

  assign in_cfg  = addr < VEC_BASE;
  assign in_vec  = (addr >= VEC_BASE) && (addr < VEC_END);
  assign reg_idx = addr[IDX_W-1:0];
  assign vec_rd  = rd_en && (addr == A_VEC_READ);
  assign eoi_wr  = wr_en && (addr == A_EOI);
  assign push    = vec_rd && found;

  vic_src_sync #(.NUM_SRC(NUM_SRC)) sync_i (
    .clk(clk), .rst(rst), .src_i(src_i), .edge_mode(edge_q), .clr(clr), .pend(pend)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .req(pend & en_q), .prio(prio_q), .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  vic_level_stack #(.DEPTH(DEPTH), .LVL_W(PRIO_W)) stk_i (
    .clk(clk), .rst(rst), .push(push), .push_lvl(win_lvl), .pop(eoi_wr),
    .empty(stk_empty), .full(stk_full), .top_lvl(top_lvl), .depth(stk_depth)
  );

  always_comb begin
    clr = '0;
    if (push) clr[win_idx] = 1'b1;
  end

  assign req_hit = found && (stk_empty || win_lvl > top_lvl) && !(stk_full && push);

  // configuration and enables
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      edge_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      if (in_cfg) begin
        prio_q[reg_idx] <= wdata[PRIO_W-1:0];
        edge_q[reg_idx] <= wdata[MODE_BIT];
      end
      if (addr == A_EN_SET) en_q <= en_q | wdata[NUM_SRC-1:0];
      if (addr == A_EN_CLR) en_q <= en_q & ~wdata[NUM_SRC-1:0];
    end
  end

  // handler address memory (no reset, single write port)
  always_ff @(posedge clk) begin
    if (wr_en && in_vec) vec_mem[reg_idx] <= wdata;
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      if (in_cfg)
        rdata <= DATA_W'({edge_q[reg_idx], 1'b0, prio_q[reg_idx]});
      else if (in_vec)
        rdata <= vec_mem[reg_idx];
      else if (vec_rd)
        rdata <= found ? vec_mem[win_idx] : '0;
      else if (addr == A_EN_SET)
        rdata <= DATA_W'(en_q);
      else
        rdata <= '0;
    end
  end

  // registered request line, released on the edge taking a vector read
  always_ff @(posedge clk) begin
    if (rst)         irq_n <= 1'b1;
    else if (vec_rd) irq_n <= 1'b1;
    else             irq_n <= !req_hit;
  end
endmodule

// File: rtl/vic_nest_chk.sv
module vic_nest_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq_n,
  input logic [CNT_W-1:0]  depth
);
  logic vrd, eoi;
  assign vrd = rd_en && (addr == vic_pkg::A_VEC_READ);
  assign eoi = wr_en && (addr == vic_pkg::A_EOI);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq_n && depth == '0)); // R1
  AST_VEC_READ_RELEASE: assert property (@(posedge clk) disable iff (rst) vrd |=> irq_n); // R4
  AST_NO_PUSH_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
    !vrd |=> depth <= $past(depth)); // R3
  AST_EOI_POP: assert property (@(posedge clk) disable iff (rst)
    (eoi && depth != '0) |=> (depth + 1'b1) == $past(depth)); // R8
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH)); // R8
  AST_EOI_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eoi && depth == '0) |=> depth == '0); // R9
endmodule

bind vic_nest_top vic_nest_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .irq_n(irq_n), .depth(stk_depth)
);

// File: tb/vic_nest_top_tb_top.sv
`timescale 1ns/1ps
module vic_nest_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;
  int          checks = 0, errors = 0;
  bit          done = 0;
  logic [2:0]  bprio [32];
  logic [31:0] d;

  always #5 clk = ~clk;

  vic_nest_top dut_i (
    .clk(clk), .rst(rst), .src_i(src), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  function automatic logic [31:0] vec_of(int i);
    return 32'h1000 + 32'(i) * 32'h10;
  endfunction

  function automatic logic [31:0] exp_vec(logic [31:0] mask);
    int best = -1;
    for (int i = 0; i < 32; i++)
      if (mask[i] && (best < 0 || bprio[i] > bprio[best])) best = i;
    return (best < 0) ? 32'h0 : vec_of(best);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic cfg(int i, logic [2:0] p, logic edge_m);
    bprio[i] = p;
    bus_wr(8'(i), {27'b0, edge_m, 1'b0, p});
  endtask

  task automatic pulse(int i);
    @(negedge clk); src[i] = 1'b1;
    wait_n(3); src[i] = 1'b0;
    wait_n(5);
  endtask

  task automatic eoi();
    bus_wr(8'h43, 32'h0);
    wait_n(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    wait_n(3);
    chk("R1 irq_n in reset", 32'(irq_n), 32'h1);
    chk("R1 rdata in reset", rdata, 32'h0);
    rst = 1'b0;
    bus_rd(8'h41, d); chk("R1 enable mask", d, 32'h0);
    bus_rd(8'h40, d); chk("R3 empty vector read", d, 32'h0);
    chk("R1 irq_n idle", 32'(irq_n), 32'h1);

    // R10 config and handler addresses
    cfg(0, 3'd2, 1'b0); cfg(1, 3'd5, 1'b1); cfg(2, 3'd5, 1'b0);
    cfg(3, 3'd7, 1'b1); cfg(4, 3'd1, 1'b0); cfg(5, 3'd3, 1'b0);
    for (int i = 0; i < 32; i++) bus_wr(8'h20 + 8'(i), vec_of(i));
    bus_rd(8'h01, d); chk("R10 config readback", d, 32'h15);
    bus_rd(8'h04, d); chk("R10 config readback", d, 32'h01);
    bus_rd(8'h23, d); chk("R10 vector readback", d, 32'h1030);

    // R11 enables
    bus_wr(8'h41, 32'h0F); bus_rd(8'h41, d); chk("R11 set", d, 32'h0F);
    bus_wr(8'h41, 32'h30); bus_rd(8'h41, d); chk("R11 set keeps", d, 32'h3F);
    bus_wr(8'h42, 32'h12); bus_rd(8'h41, d); chk("R11 clear", d, 32'h2D);
    bus_wr(8'h41, 32'h12); bus_wr(8'h42, 32'h10);
    bus_rd(8'h41, d); chk("R11 mask", d, 32'h2F);

    // R2 disabled / enabled, R6 level behaviour
    @(negedge clk); src[4] = 1'b1; wait_n(5);
    chk("R2 disabled source quiet", 32'(irq_n), 32'h1);
    bus_wr(8'h41, 32'h10); wait_n(1);
    chk("R2 enabled source asserts", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R3 vector src4", d, 32'h1040);
    chk("R4 release on read", 32'(irq_n), 32'h1);
    wait_n(2); chk("R7 equal level stays quiet", 32'(irq_n), 32'h1);
    eoi(); chk("R6 level source still pending", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R6 vector again", d, 32'h1040);
    @(negedge clk); src[4] = 1'b0; wait_n(4);
    eoi(); chk("R6 level follows input", 32'(irq_n), 32'h1);

    // R5 edge, R3 tie, R7 nesting, R8 pop
    @(negedge clk); src[2] = 1'b1;
    pulse(1);
    chk("R5 sticky edge pending", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R3 tie lowest index", d, 32'h1010);
    chk("R4 release", 32'(irq_n), 32'h1);
    wait_n(2); chk("R7 equal priority blocked", 32'(irq_n), 32'h1);
    pulse(3);
    chk("R7 higher nests", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R3 vector src3", d, 32'h1030);
    eoi(); chk("R8 restored level 5 blocks src2", 32'(irq_n), 32'h1);
    eoi(); chk("R8 empty stack reasserts", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R5 edge cleared so src2 wins", d, 32'h1020);
    @(negedge clk); src[2] = 1'b0; wait_n(4);
    eoi(); chk("R5 edge flags cleared", 32'(irq_n), 32'h1);

    // R8 reassert for lower than finished level
    @(negedge clk); src[0] = 1'b1; wait_n(5);
    chk("R2 src0 asserts", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R3 vector src0", d, 32'h1000);
    pulse(1);
    chk("R7 nest over level 2", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R3 vector src1", d, 32'h1010);
    @(negedge clk); src[5] = 1'b1; wait_n(5);
    chk("R7 lower blocked", 32'(irq_n), 32'h1);
    eoi(); chk("R8 lower than finished reasserts", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R3 vector src5", d, 32'h1050);
    @(negedge clk); src[5] = 1'b0; src[0] = 1'b0; wait_n(4);
    eoi(); eoi(); chk("R8 all done", 32'(irq_n), 32'h1);

    // R9 end of interrupt on empty stack
    eoi(); eoi(); chk("R9 empty eoi quiet", 32'(irq_n), 32'h1);
    @(negedge clk); src[4] = 1'b1; wait_n(5);
    chk("R9 stack still empty", 32'(irq_n), 32'h0);
    bus_rd(8'h40, d); chk("R9 vector after empty eoi", d, 32'h1040);
    @(negedge clk); src[4] = 1'b0; wait_n(4);
    eoi(); chk("R9 back to idle", 32'(irq_n), 32'h1);

    // random priorities and request sets, all level mode
    for (int i = 0; i < 32; i++) cfg(i, 3'($urandom), 1'b0);
    bus_wr(8'h41, 32'hFFFF_FFFF);
    for (int k = 0; k < 24; k++) begin
      logic [31:0] m;
      m = $urandom;
      if (k % 4 == 0) m = m & (32'h1 << (k % 32)) | 32'h8000_0000;
      if (m == 0) m = 32'h1;
      @(negedge clk); src = m; wait_n(5);
      chk("R2 random request", 32'(irq_n), 32'h0);
      bus_rd(8'h40, d); chk("R3 random winner", d, exp_vec(m));
      chk("R4 random release", 32'(irq_n), 32'h1);
      @(negedge clk); src = '0; wait_n(4);
      eoi(); chk("R8 random idle", 32'(irq_n), 32'h1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule